// File: doc/BRIEF.md
# SMBus Block Data Buffer

This block holds the data bytes of an SMBus block transfer between a host register port and the transaction engine that drives the bus. With the buffered mode bit set, the host fills up to 32 bytes before the engine starts a block write, or empties them after a block read ends. A separate host index and engine index step through the storage. When the mode bit is clear, or when the transfer is an I2C-style block read, the storage shrinks to one byte register. Each byte then passes between host and engine under a byte-done handshake: the engine raises the flag and waits until the host writes a one to clear it.

The host index returns to zero whenever the host reads its control register. The engine index returns to zero when a new transfer starts. Both indexes also return to zero when the mode bit is cleared. The block also holds the length register, flags a received length that is outside 1..32, and gives the engine a byte count that is always clamped to 1..32.

Top module: `smb_blkbuf`

## Requirements
- R1: A write to the auxiliary mode bit sets `mode_q` to the written value when the buffer is built in (HAS_BUF=1). With HAS_BUF=0, `mode_q` always reads 0.
- R2: A host read of the control register (`ctl_rd`) sets the host index to 0. The next data access then uses byte 0.
- R3: In buffered mode, each host data write stores into the byte at the host index and then advances the index. Writes made when the index has reached 32 are ignored and change no stored byte.
- R4: In buffered mode, a host data read returns the byte at the host index and advances the index. If the index is not below the length register, or has reached 32, the read returns 0x00.
- R5: In buffered mode, engine pops and pushes use a separate engine index that `eng_start` clears. Pops return stored bytes in order, and pushes store received bytes in order for the host to drain. A pop at index 32 returns 0x00.
- R6: An engine length write loads the length register and sets `len_err` when the value is 0 or above 32, and clears it otherwise. A host length write or `eng_start` clears `len_err`. An engine length write wins over a host length write in the same cycle.
- R7: `xfer_cnt` equals the length register clamped into 1..32: 0 gives 1, and any value above 32 gives 32.
- R8: In unbuffered mode, host writes, host reads, engine pushes and engine pops all use the one byte at position 0, and no index moves.
- R9: In unbuffered mode, every engine push or pop sets `byte_done`. The flag then stays set until a cycle with `done_clr` and no engine access. If a set and a clear happen in the same cycle, the set wins.
- R10: While `i2c_rd_mode` is high, the block behaves as in unbuffered mode even when `mode_q` is 1.
- R11: Clearing the mode bit from 1 to 0 sets both the host index and the engine index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aux_wr | input | 1 | Host write strobe for the mode bit |
| aux_mode_d | input | 1 | Mode bit value written |
| mode_q | output | 1 | Mode bit as read back by the host |
| ctl_rd | input | 1 | Host read of the control register; resets the host index |
| len_wr | input | 1 | Host write strobe for the length register |
| len_d | input | 8 | Host length value |
| len_q | output | 8 | Length register |
| dat_wr | input | 1 | Host write strobe for the block data register |
| dat_d | input | 8 | Host data byte |
| dat_rd | input | 1 | Host read strobe for the block data register |
| dat_q | output | 8 | Host read data, valid in the strobe cycle |
| done_clr | input | 1 | Host writes 1 to the byte-done status bit |
| byte_done | output | 1 | Byte-done flag (unbuffered handshake) |
| i2c_rd_mode | input | 1 | Current transfer is an I2C-style block read |
| eng_start | input | 1 | Engine begins a transfer; clears the engine index and len_err |
| eng_len_we | input | 1 | Engine writes the received length |
| eng_len_d | input | 8 | Received length value |
| eng_push | input | 1 | Engine stores a received byte |
| eng_push_d | input | 8 | Received byte |
| eng_pop | input | 1 | Engine takes the next byte to send |
| eng_pop_d | output | 8 | Byte for the engine, valid in the pop cycle |
| len_err | output | 1 | Received length outside 1..32 |
| xfer_cnt | output | 6 | Clamped byte count for the engine |

## Verification
`dat_q` and `eng_pop_d` are combinational on the state before the edge. The bench samples them 1 ns after it raises the strobe, in that same cycle. Index moves, stored bytes, `byte_done`, `len_q`, `len_err` and `mode_q` all change at the next rising edge, and `xfer_cnt` follows `len_q` in the same cycle. The bench therefore checks them 1 ns after that edge and relies on the effect of a read strobe only at the next access. Random mixes of operations in both modes run against a bench model, and directed cases cover the index-32 limit, the length bounds and a byte-done set and clear in the same cycle.

// File: rtl/smb_blkbuf_pkg.sv
package smb_blkbuf_pkg;

  // True when a received length lies inside 1..max.
  function automatic logic len_legal(input int l, input int max);
    return (l >= 1) && (l <= max);
  endfunction

  // Byte count the engine is allowed to run, forced into 1..max.
  function automatic int clamp_len(input int l, input int max);
    int r;
    r = l;
    if (r < 1) r = 1;
    if (r > max) r = max;
    return r;
  endfunction

endpackage

// File: rtl/smb_blkbuf_idx.sv
module smb_blkbuf_idx #(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

  // clear wins over advance; the index parks at DEPTH
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   idx <= '0;
    else if (clr)                 idx <= '0;
    else if (inc && idx < LIMIT)  idx <= idx + 1'b1;
  end
endmodule

// File: rtl/smb_blkbuf_store.sv
module smb_blkbuf_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_en,
  input  logic [IDX_W-1:0]  hw_idx,
  input  logic [DATA_W-1:0] hw_d,
  input  logic              ew_en,
  input  logic [IDX_W-1:0]  ew_idx,
  input  logic [DATA_W-1:0] ew_d,
  input  logic [IDX_W-1:0]  hr_idx,
  output logic [DATA_W-1:0] hr_q,
  input  logic [IDX_W-1:0]  er_idx,
  output logic [DATA_W-1:0] er_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    // engine write takes priority on a same-byte collision
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mem[g] <= '0;
      else if (ew_en && ew_idx == IDX_W'(g))       mem[g] <= ew_d;
      else if (hw_en && hw_idx == IDX_W'(g))       mem[g] <= hw_d;
    end
  end

  // out-of-range indexes read as zero
  always_comb begin
    hr_q = '0;
    er_q = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hr_idx == IDX_W'(i)) hr_q = mem[i];
      if (er_idx == IDX_W'(i)) er_q = mem[i];
    end
  end
endmodule

// File: rtl/smb_blkbuf.sv
module smb_blkbuf
  import smb_blkbuf_pkg::*;
#(
  parameter int   DEPTH   = 32,
  parameter int   DATA_W  = 8,
  parameter int   LEN_W   = 8,
  parameter bit   HAS_BUF = 1'b1,
  parameter int   IDX_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aux_wr,
  input  logic              aux_mode_d,
  output logic              mode_q,
  input  logic              ctl_rd,
  input  logic              len_wr,
  input  logic [LEN_W-1:0]  len_d,
  output logic [LEN_W-1:0]  len_q,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] dat_d,
  input  logic              dat_rd,
  output logic [DATA_W-1:0] dat_q,
  input  logic              done_clr,
  output logic              byte_done,
  input  logic              i2c_rd_mode,
  input  logic              eng_start,
  input  logic              eng_len_we,
  input  logic [LEN_W-1:0]  eng_len_d,
  input  logic              eng_push,
  input  logic [DATA_W-1:0] eng_push_d,
  input  logic              eng_pop,
  output logic [DATA_W-1:0] eng_pop_d,
  output logic              len_err,
  output logic [IDX_W-1:0]  xfer_cnt
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

  // named internal events used by the checker
  logic             buf_eff;
  logic             mode_fall;
  logic             done_set;
  logic [IDX_W-1:0] hidx, eidx, h_ptr, e_ptr;
  logic [DATA_W-1:0] h_raw, e_raw;

  assign buf_eff   = mode_q & ~i2c_rd_mode;
  assign mode_fall = aux_wr & mode_q & ~aux_mode_d;
  assign done_set  = ~buf_eff & (eng_push | eng_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= 1'b0;
    else if (aux_wr) mode_q <= aux_mode_d & HAS_BUF;
  end

  smb_blkbuf_idx #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_hidx (
    .clk(clk), .rst_n(rst_n),
    .clr(ctl_rd | mode_fall),
    .inc(buf_eff & (dat_wr | dat_rd)),
    .idx(hidx)
  );

  smb_blkbuf_idx #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_eidx (
    .clk(clk), .rst_n(rst_n),
    .clr(eng_start | mode_fall),
    .inc(buf_eff & (eng_push | eng_pop)),
    .idx(eidx)
  );

  // unbuffered: everything collapses onto byte 0
  assign h_ptr = buf_eff ? hidx : '0;
  assign e_ptr = buf_eff ? eidx : '0;

  smb_blkbuf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .hw_en(dat_wr & (h_ptr < LIMIT)), .hw_idx(h_ptr), .hw_d(dat_d),
    .ew_en(eng_push & (e_ptr < LIMIT)), .ew_idx(e_ptr), .ew_d(eng_push_d),
    .hr_idx(h_ptr), .hr_q(h_raw),
    .er_idx(e_ptr), .er_q(e_raw)
  );

  always_comb begin
    if (!buf_eff)                       dat_q = h_raw;
    else if (32'(hidx) < 32'(len_q))    dat_q = h_raw;
    else                                dat_q = '0;
  end
  assign eng_pop_d = e_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        byte_done <= 1'b0;
    else if (done_set) byte_done <= 1'b1;
    else if (done_clr) byte_done <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      len_err <= 1'b0;
    end else if (eng_len_we) begin
      len_q   <= eng_len_d;
      len_err <= ~len_legal(int'(eng_len_d), DEPTH);
    end else begin
      if (len_wr) len_q <= len_d;
      if (len_wr || eng_start) len_err <= 1'b0;
    end
  end

  assign xfer_cnt = IDX_W'(clamp_len(int'(len_q), DEPTH));
endmodule

// File: rtl/smb_blkbuf_chk.sv
module smb_blkbuf_chk #(
  parameter int DEPTH   = 32,
  parameter int IDX_W   = 6,
  parameter int LEN_W   = 8,
  parameter bit HAS_BUF = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_rd,
  input logic             mode_q,
  input logic             done_clr,
  input logic             done_set,
  input logic             byte_done,
  input logic             len_err,
  input logic [LEN_W-1:0] len_q,
  input logic [IDX_W-1:0] xfer_cnt,
  input logic [IDX_W-1:0] hidx,
  input logic [IDX_W-1:0] eidx
);
  p_mode_present_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> HAS_BUF);

  p_ctl_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd |=> (hidx == '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(hidx) <= DEPTH) && (32'(eidx) <= DEPTH));

  p_len_err_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> (len_q == '0 || 32'(len_q) > DEPTH));

  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_cnt != '0) && (32'(xfer_cnt) <= DEPTH));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !done_clr) |=> byte_done);

  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !done_set) |=> !byte_done);

  p_mode_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_q) |-> (hidx == '0 && eidx == '0));
endmodule

bind smb_blkbuf smb_blkbuf_chk #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W), .HAS_BUF(HAS_BUF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_rd(ctl_rd), .mode_q(mode_q),
  .done_clr(done_clr), .done_set(done_set), .byte_done(byte_done),
  .len_err(len_err), .len_q(len_q), .xfer_cnt(xfer_cnt),
  .hidx(hidx), .eidx(eidx)
);

// File: tb/smb_blkbuf_tb.sv
module smb_blkbuf_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic aux_wr = 0, aux_mode_d = 0, ctl_rd = 0, len_wr = 0, dat_wr = 0, dat_rd = 0;
  logic done_clr = 0, i2c_rd_mode = 0, eng_start = 0, eng_len_we = 0, eng_push = 0, eng_pop = 0;
  logic [7:0] len_d = 0, dat_d = 0, eng_len_d = 0, eng_push_d = 0;
  logic mode_q, byte_done, len_err, nb_mode, nb_done, nb_err;
  logic [7:0] len_q, dat_q, eng_pop_d, nb_len, nb_dat, nb_pop;
  logic [5:0] xfer_cnt, nb_cnt;

  always #2 clk = ~clk;

  smb_blkbuf u_dut (
    .clk(clk), .rst_n(rst_n), .aux_wr(aux_wr), .aux_mode_d(aux_mode_d), .mode_q(mode_q),
    .ctl_rd(ctl_rd), .len_wr(len_wr), .len_d(len_d), .len_q(len_q),
    .dat_wr(dat_wr), .dat_d(dat_d), .dat_rd(dat_rd), .dat_q(dat_q),
    .done_clr(done_clr), .byte_done(byte_done), .i2c_rd_mode(i2c_rd_mode),
    .eng_start(eng_start), .eng_len_we(eng_len_we), .eng_len_d(eng_len_d),
    .eng_push(eng_push), .eng_push_d(eng_push_d), .eng_pop(eng_pop), .eng_pop_d(eng_pop_d),
    .len_err(len_err), .xfer_cnt(xfer_cnt)
  );

  smb_blkbuf #(.HAS_BUF(1'b0)) u_nobuf (
    .clk(clk), .rst_n(rst_n), .aux_wr(aux_wr), .aux_mode_d(aux_mode_d), .mode_q(nb_mode),
    .ctl_rd(1'b0), .len_wr(1'b0), .len_d(8'h0), .len_q(nb_len),
    .dat_wr(1'b0), .dat_d(8'h0), .dat_rd(1'b0), .dat_q(nb_dat),
    .done_clr(1'b0), .byte_done(nb_done), .i2c_rd_mode(1'b0),
    .eng_start(1'b0), .eng_len_we(1'b0), .eng_len_d(8'h0),
    .eng_push(1'b0), .eng_push_d(8'h0), .eng_pop(1'b0), .eng_pop_d(nb_pop),
    .len_err(nb_err), .xfer_cnt(nb_cnt)
  );

  int nchk = 0, nerr = 0;
  bit finished = 0;

  // bench model of the requirements
  logic [7:0] m_mem [32];
  int m_hidx = 0, m_eidx = 0, m_len = 0;
  bit m_mode = 0, m_done = 0, m_err = 0;

  function automatic bit m_buf();
    return m_mode && !i2c_rd_mode;
  endfunction
  function automatic int exp_cnt(int l);
    if (l == 0) return 1;
    else if (l > 32) return 32;
    else return l;
  endfunction
  function automatic bit exp_bad(int l);
    return (l == 0) || (l > 32);
  endfunction
  function automatic logic [7:0] exp_hrd();
    if (!m_buf()) return m_mem[0];
    if (m_hidx >= 32 || m_hidx >= m_len) return 8'h00;
    return m_mem[m_hidx];
  endfunction
  function automatic logic [7:0] exp_pop();
    if (!m_buf()) return m_mem[0];
    if (m_eidx >= 32) return 8'h00;
    return m_mem[m_eidx];
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(string tag);
    chk({tag, " R1 mode_q"}, int'(mode_q), int'(m_mode));
    chk({tag, " R6 len_q"}, int'(len_q), m_len);
    chk({tag, " R6 len_err"}, int'(len_err), int'(m_err));
    chk({tag, " R7 xfer_cnt"}, int'(xfer_cnt), exp_cnt(m_len));
    chk({tag, " R9 byte_done"}, int'(byte_done), int'(m_done));
  endtask

  task automatic edge_end();
    @(posedge clk); #1;
    aux_wr = 0; ctl_rd = 0; len_wr = 0; dat_wr = 0; dat_rd = 0; done_clr = 0;
    eng_start = 0; eng_len_we = 0; eng_push = 0; eng_pop = 0;
  endtask

  task automatic set_mode(bit b);
    @(negedge clk); aux_wr = 1; aux_mode_d = b; edge_end();
    if (m_mode && !b) begin m_hidx = 0; m_eidx = 0; end
    m_mode = b;
  endtask
  task automatic do_ctl_rd();
    @(negedge clk); ctl_rd = 1; edge_end(); m_hidx = 0;
  endtask
  task automatic host_wr(logic [7:0] d);
    @(negedge clk); dat_wr = 1; dat_d = d; edge_end();
    if (!m_buf()) m_mem[0] = d;
    else if (m_hidx < 32) begin m_mem[m_hidx] = d; m_hidx++; end
  endtask
  task automatic host_rd(string tag);
    @(negedge clk); dat_rd = 1; #1;
    chk(tag, int'(dat_q), int'(exp_hrd()));
    edge_end();
    if (m_buf() && m_hidx < 32) m_hidx++;
  endtask
  task automatic eng_begin();
    @(negedge clk); eng_start = 1; edge_end(); m_eidx = 0; m_err = 0;
  endtask
  task automatic eng_psh(logic [7:0] d, bit clr);
    @(negedge clk); eng_push = 1; eng_push_d = d; done_clr = clr; edge_end();
    if (!m_buf()) begin m_mem[0] = d; m_done = 1; end
    else begin
      if (m_eidx < 32) begin m_mem[m_eidx] = d; m_eidx++; end
      if (clr) m_done = 0;
    end
  endtask
  task automatic eng_pp(string tag);
    @(negedge clk); eng_pop = 1; #1;
    chk(tag, int'(eng_pop_d), int'(exp_pop()));
    edge_end();
    if (!m_buf()) m_done = 1;
    else if (m_eidx < 32) m_eidx++;
  endtask
  task automatic host_len(logic [7:0] d);
    @(negedge clk); len_wr = 1; len_d = d; edge_end(); m_len = d; m_err = 0;
  endtask
  task automatic eng_len(logic [7:0] d);
    @(negedge clk); eng_len_we = 1; eng_len_d = d; edge_end(); m_len = d; m_err = exp_bad(d);
  endtask
  task automatic clr_done();
    @(negedge clk); done_clr = 1; edge_end(); m_done = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) m_mem[i] = 8'h00;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk_regs("reset");

    // R1: mode bit readback, with and without the buffer built in
    set_mode(1);
    chk("R1 mode set", int'(mode_q), 1);
    chk("R1 absent feature reads 0", int'(nb_mode), 0);

    // R3/R4: fill past the end, then drain the full block
    do_ctl_rd();
    for (int i = 0; i < 32; i++) host_wr(8'(i + 8'h10));
    host_wr(8'hEE);
    host_len(32);
    do_ctl_rd();
    for (int i = 0; i < 32; i++) host_rd("R3/R4 full block readback");
    chk("R3 byte 31 kept, write 33 ignored", int'(m_mem[31]), 8'h2F);
    host_rd("R4 read at index 32 returns 0");

    // R2/R4: short length, reads past it are zero
    host_len(3);
    do_ctl_rd();
    for (int i = 0; i < 5; i++) host_rd("R2/R4 short length read");

    // R5: engine pops in order, then pushes for host drain
    eng_begin();
    for (int i = 0; i < 3; i++) eng_pp("R5 engine pop order");
    eng_begin();
    for (int i = 0; i < 4; i++) eng_psh(8'(8'hA0 + i), 0);
    eng_len(4);
    do_ctl_rd();
    for (int i = 0; i < 5; i++) host_rd("R5 host drains pushed bytes");
    eng_begin();
    for (int i = 0; i < 33; i++) eng_pp("R5 engine pop incl. index 32");
    chk_regs("R5 after engine traffic");

    // R6/R7: length bounds
    eng_len(0);  chk_regs("R6 length 0");
    eng_len(40); chk_regs("R6 length 40");
    eng_len(32); chk_regs("R6 length 32");
    eng_len(33); chk_regs("R6 length 33");
    host_len(5); chk_regs("R6 host length clears flag");
    eng_len(1);  chk_regs("R7 length 1");

    // R11: clearing mode resets both indexes
    host_len(8);
    do_ctl_rd();
    host_rd("R11 setup"); host_rd("R11 setup");
    eng_begin(); eng_pp("R11 setup");
    set_mode(0); set_mode(1);
    host_rd("R11 host index back at 0");
    eng_pp("R11 engine index back at 0");

    // R8/R9: unbuffered single byte with handshake
    set_mode(0);
    host_wr(8'h5A);
    eng_pp("R8 engine sees host byte");
    chk("R9 done set by pop", int'(byte_done), 1);
    host_wr(8'h6B);
    chk("R9 done held without clear", int'(byte_done), 1);
    clr_done();
    chk("R9 done cleared by host", int'(byte_done), 0);
    eng_psh(8'h77, 0);
    host_rd("R8 host reads pushed byte");
    host_rd("R8 second read same byte, no index move");
    clr_done();
    eng_psh(8'h78, 1);
    chk("R9 set wins over same-cycle clear", int'(byte_done), 1);
    clr_done();

    // R10: I2C-style read bypasses the buffer even with mode set
    set_mode(1);
    i2c_rd_mode = 1;
    eng_psh(8'h3C, 0);
    chk("R10 done set in bypass", int'(byte_done), 1);
    host_rd("R10 byte 0 path");
    host_rd("R10 byte 0 path repeat");
    clr_done();
    i2c_rd_mode = 0;
    chk_regs("R10 after bypass");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 13);
      case (op)
        0, 1:  host_wr(8'($urandom));
        2, 3:  host_rd("R4 random host read");
        4:     do_ctl_rd();
        5:     eng_begin();
        6, 7:  eng_psh(8'($urandom), 1'($urandom_range(0, 1)));
        8, 9:  eng_pp("R5 random engine pop");
        10:    host_len(8'($urandom_range(0, 40)));
        11:    eng_len(8'($urandom_range(0, 40)));
        12:    clr_done();
        default: begin
          if ($urandom_range(0, 3) == 0) set_mode(1'($urandom_range(0, 1)));
          else i2c_rd_mode = 1'($urandom_range(0, 1));
        end
      endcase
      if (it % 10 == 0) chk_regs("R8 random state");
    end
    i2c_rd_mode = 0;
    chk_regs("final");
    finish_run();
  end
endmodule